// File: doc/BRIEF.md
# Transactional Cache Tracking-Set Controller

This block models best-effort hardware transactions for a few processes that share a small word-addressed memory. Each process owns a tracking set of at most `TS` entries. An entry holds an address, a speculative value and a mode, either shared or exclusive. A process issues one of three request kinds through its own port:

- a cached read-modify-write, which works on its tracking set;
- a direct access, which works on memory at once;
- a commit, which publishes the exclusive entries of its set.

Every cached access first tests capacity, then the validity of the requester's own set, then conflicts with the sets of the other processes. An access that fails a test empties the requester's set and returns an abort status. A direct access never creates an entry, but it can invalidate other processes' sets. An invalidated set stays in place until its owner's next cached access or commit, which then reports a tracking-set abort. A commit on a valid set writes all its exclusive entries to memory in a single clock edge.

Requests from all processes pass through a fixed-priority arbiter, one per cycle. This makes every check and every invalidation atomic with respect to the others. The result appears on the response outputs one cycle after the grant.

Top module: `tset_ctrl`

## Requirements
- R1: After reset every tracking set is empty and valid, all memory words read as zero, and no response is valid.
- R2: Arbitration and response format.
  - One request is granted per cycle: the requesting process with the lowest index.
  - `rsp_vld` for that process is high in the next cycle.
  - The status codes are 0 = ok, 1 = capacity abort, 2 = conflict abort, 3 = tracking-set abort.
  - Any abort returns data zero.
- R3: Direct access (`kind` = 1) executes the opcode on memory in the same cycle and returns the old memory value. The opcodes are 0 = read, 1 = store `wdata`, 2 = add `wdata`, 3 = compare-and-set (store `wdata` if the old value equals `cmp`). A direct access creates no tracking entry.
- R4: Cached access (`kind` = 0) value and entry.
  - The access returns the requester's own entry value if it already holds the address; otherwise it returns the memory value.
  - A nontrivial opcode installs or updates the entry as exclusive, with the new value.
  - A trivial opcode installs the entry as shared.
  - Memory is not changed until commit.
- R5: A compare-and-set whose comparison fails is trivial. It installs a shared entry and writes nothing.
- R6: Capacity abort.
  - A cached access to a set that already holds `TS` entries returns a capacity abort and empties the set.
  - This check comes before all other checks, even when the address is already held or the set is invalid.
  - Repeated accesses to one address reuse a single entry.
- R7: Conflict abort.
  - A trivial cached access conflicts when another process holds the address exclusive.
  - A nontrivial cached access conflicts when another process holds the address in any mode.
  - On a conflict the requester's set is emptied; the other sets are not affected.
- R8: Invalidation.
  - An access by another process to an address that a set holds exclusive invalidates that set.
  - A nontrivial access by another process to an address that a set holds shared also invalidates it.
  - A trivial direct access to a shared address leaves the set valid.
- R9: On an invalid set, the owner's next cached access or commit returns a tracking-set abort (`kind` 2 or 3 is commit). It empties the set and makes it valid again.
- R10: A commit on a valid set writes every exclusive entry's value to memory in one clock edge, discards shared entries without writing, empties the set and returns ok.
- R11: A transaction that aborts leaves memory exactly as it was before the transaction began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NPROC | Request valid per process, held until granted |
| req_kind | input | 2*NPROC | Per process: 0 cached, 1 direct, 2/3 commit |
| req_op | input | 2*NPROC | Per process: 0 read, 1 store, 2 add, 3 compare-and-set |
| req_addr | input | TX_AW*NPROC | Per process word address |
| req_wdata | input | TX_DW*NPROC | Per process store/add operand |
| req_cmp | input | TX_DW*NPROC | Per process compare value |
| req_gnt | output | NPROC | One-hot grant, same cycle as the request |
| rsp_vld | output | NPROC | Response valid, one cycle after grant |
| rsp_data | output | TX_DW*NPROC | Old value seen by the access, zero on abort |
| rsp_stat | output | 2*NPROC | Status code per process |

## Verification
The bench builds the block with three processes and a capacity of two entries. With two entries a set fills after two distinct addresses, so capacity aborts can be reached quickly. The capacity-before-tracking ordering can also be shown with a full set that another process has invalidated. Three processes allow a holder, a conflicting requester and a third process that issues direct accesses all at once. This exercises conflict, invalidation and arbitration between non-adjacent indices.

// File: rtl/tset_pkg.sv
package tset_pkg;

    parameter int unsigned TX_AW = 4;
    parameter int unsigned TX_DW = 8;

    typedef enum logic [1:0] {
        K_CACHED = 2'd0,
        K_DIRECT = 2'd1,
        K_COMMIT = 2'd2,
        K_COMMIT_ALT = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_STORE = 2'd1,
        OP_ADD   = 2'd2,
        OP_CAS   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_CAP   = 2'd1,
        ST_CONF  = 2'd2,
        ST_TRACK = 2'd3
    } stat_e;

    typedef struct packed {
        logic             vld;
        logic             excl;
        logic [TX_AW-1:0] addr;
        logic [TX_DW-1:0] val;
    } tent_t;

endpackage

// File: rtl/tset_arb.sv
module tset_arb #(
    parameter int unsigned N = 3,
    localparam int unsigned XW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [XW-1:0] idx_o,
    output logic          any_o
);
    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int p = N - 1; p >= 0; p--) begin
            if (req_i[p]) begin
                gnt_o    = '0;
                gnt_o[p] = 1'b1;
                idx_o    = XW'(p);
                any_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tset_alu.sv
module tset_alu
    import tset_pkg::*;
(
    input  op_e              op_i,
    input  logic [TX_DW-1:0] cur_i,
    input  logic [TX_DW-1:0] wdata_i,
    input  logic [TX_DW-1:0] cmp_i,
    output logic [TX_DW-1:0] new_o,
    output logic             nontriv_o
);
    always_comb begin
        new_o     = cur_i;
        nontriv_o = 1'b0;
        case (op_i)
            OP_READ: begin
                new_o     = cur_i;
                nontriv_o = 1'b0;
            end
            OP_STORE: begin
                new_o     = wdata_i;
                nontriv_o = 1'b1;
            end
            OP_ADD: begin
                new_o     = cur_i + wdata_i;
                nontriv_o = 1'b1;
            end
            default: begin
                // failed compare leaves the access trivial
                if (cur_i == cmp_i) begin
                    new_o     = wdata_i;
                    nontriv_o = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/tset_lookup.sv
module tset_lookup
    import tset_pkg::*;
#(
    parameter int unsigned TS = 2,
    localparam int unsigned IW = (TS > 1) ? $clog2(TS) : 1,
    localparam int unsigned CW = $clog2(TS + 1)
) (
    input  tent_t [TS-1:0]   set_i,
    input  logic [TX_AW-1:0] addr_i,
    output logic             hit_o,
    output logic [IW-1:0]    hidx_o,
    output logic [TX_DW-1:0] hval_o,
    output logic             hexcl_o,
    output logic [CW-1:0]    cnt_o,
    output logic [IW-1:0]    fidx_o
);
    always_comb begin
        hit_o   = 1'b0;
        hidx_o  = '0;
        hval_o  = '0;
        hexcl_o = 1'b0;
        cnt_o   = '0;
        fidx_o  = '0;
        for (int k = TS - 1; k >= 0; k--) begin
            if (set_i[k].vld) begin
                cnt_o = cnt_o + CW'(1);
                if (set_i[k].addr == addr_i) begin
                    hit_o   = 1'b1;
                    hidx_o  = IW'(k);
                    hval_o  = set_i[k].val;
                    hexcl_o = set_i[k].excl;
                end
            end else begin
                fidx_o = IW'(k);
            end
        end
    end
endmodule

// File: rtl/tset_ctrl.sv
module tset_ctrl
    import tset_pkg::*;
#(
    parameter int unsigned NPROC = 3,
    parameter int unsigned TS    = 2,
    localparam int unsigned DEPTH = 1 << TX_AW,
    localparam int unsigned XW    = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int unsigned IW    = (TS > 1) ? $clog2(TS) : 1,
    localparam int unsigned CW    = $clog2(TS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPROC-1:0]       req_vld,
    input  logic [2*NPROC-1:0]     req_kind,
    input  logic [2*NPROC-1:0]     req_op,
    input  logic [TX_AW*NPROC-1:0] req_addr,
    input  logic [TX_DW*NPROC-1:0] req_wdata,
    input  logic [TX_DW*NPROC-1:0] req_cmp,
    output logic [NPROC-1:0]       req_gnt,
    output logic [NPROC-1:0]       rsp_vld,
    output logic [TX_DW*NPROC-1:0] rsp_data,
    output logic [2*NPROC-1:0]     rsp_stat
);
    // tracking sets, validity flags and shared memory
    tent_t [TS-1:0]   sets_q [NPROC];
    logic [NPROC-1:0] ok_q;
    logic [TX_DW-1:0] mem_q [DEPTH];

    // arbitration
    logic [XW-1:0] sel;
    logic          any;

    tset_arb #(.N(NPROC)) u_arb (
        .req_i (req_vld),
        .gnt_o (req_gnt),
        .idx_o (sel),
        .any_o (any)
    );

    kind_e            s_kind;
    op_e              s_op;
    logic [TX_AW-1:0] s_addr;
    logic [TX_DW-1:0] s_wdata;
    logic [TX_DW-1:0] s_cmp;

    always_comb begin
        s_kind  = kind_e'(req_kind[sel*2 +: 2]);
        s_op    = op_e'(req_op[sel*2 +: 2]);
        s_addr  = req_addr[sel*TX_AW +: TX_AW];
        s_wdata = req_wdata[sel*TX_DW +: TX_DW];
        s_cmp   = req_cmp[sel*TX_DW +: TX_DW];
    end

    // per-process lookup of the selected address
    logic [NPROC-1:0] hit;
    logic [NPROC-1:0] hexcl;
    logic [IW-1:0]    hidx [NPROC];
    logic [TX_DW-1:0] hval [NPROC];
    logic [CW-1:0]    cnt  [NPROC];
    logic [IW-1:0]    fidx [NPROC];

    for (genvar gp = 0; gp < NPROC; gp++) begin : g_look
        tset_lookup #(.TS(TS)) u_look (
            .set_i   (sets_q[gp]),
            .addr_i  (s_addr),
            .hit_o   (hit[gp]),
            .hidx_o  (hidx[gp]),
            .hval_o  (hval[gp]),
            .hexcl_o (hexcl[gp]),
            .cnt_o   (cnt[gp]),
            .fidx_o  (fidx[gp])
        );
    end

    // value seen by the access and its effect
    logic [TX_DW-1:0] mem_rd;
    logic [TX_DW-1:0] cur;
    logic [TX_DW-1:0] newv;
    logic             nontriv;

    always_comb begin
        mem_rd = mem_q[s_addr];
        cur    = (s_kind == K_CACHED && hit[sel]) ? hval[sel] : mem_rd;
    end

    tset_alu u_alu (
        .op_i      (s_op),
        .cur_i     (cur),
        .wdata_i   (s_wdata),
        .cmp_i     (s_cmp),
        .new_o     (newv),
        .nontriv_o (nontriv)
    );

    // cross-set clash: other holder exclusive, or any holder vs nontrivial
    logic [NPROC-1:0] clash;
    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            clash[p] = (XW'(p) != sel) && hit[p] && (hexcl[p] || nontriv);
        end
    end

    // decision
    logic  do_abort;
    logic  do_install;
    logic  do_direct;
    logic  do_commit;
    stat_e s_stat;
    tent_t ins_ent;

    always_comb begin
        do_abort   = 1'b0;
        do_install = 1'b0;
        do_direct  = 1'b0;
        do_commit  = 1'b0;
        s_stat     = ST_OK;
        if (any) begin
            case (s_kind)
                K_CACHED: begin
                    if (cnt[sel] == CW'(TS)) begin
                        do_abort = 1'b1;
                        s_stat   = ST_CAP;
                    end else if (!ok_q[sel]) begin
                        do_abort = 1'b1;
                        s_stat   = ST_TRACK;
                    end else if (|clash) begin
                        do_abort = 1'b1;
                        s_stat   = ST_CONF;
                    end else begin
                        do_install = 1'b1;
                    end
                end
                K_DIRECT: do_direct = 1'b1;
                default: begin
                    if (!ok_q[sel]) begin
                        do_abort = 1'b1;
                        s_stat   = ST_TRACK;
                    end else begin
                        do_commit = 1'b1;
                    end
                end
            endcase
        end
        ins_ent.vld  = 1'b1;
        ins_ent.excl = nontriv || (hit[sel] && hexcl[sel]);
        ins_ent.addr = s_addr;
        ins_ent.val  = newv;
    end

    // state update
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPROC; p++) begin
                sets_q[p] <= '0;
            end
            ok_q <= '1;
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= '0;
            end
            rsp_vld  <= '0;
            rsp_data <= '0;
            rsp_stat <= '0;
        end else begin
            rsp_vld <= req_gnt;
            if (any) begin
                rsp_data[sel*TX_DW +: TX_DW] <= (do_install || do_direct) ? cur : '0;
                rsp_stat[sel*2 +: 2]         <= s_stat;
            end
            if (do_abort) begin
                sets_q[sel] <= '0;
                ok_q[sel]   <= 1'b1;
            end
            if (do_install) begin
                if (hit[sel]) begin
                    sets_q[sel][hidx[sel]] <= ins_ent;
                end else begin
                    sets_q[sel][fidx[sel]] <= ins_ent;
                end
            end
            if (do_install || do_direct) begin
                for (int p = 0; p < NPROC; p++) begin
                    if (clash[p]) begin
                        ok_q[p] <= 1'b0;
                    end
                end
            end
            if (do_direct && nontriv) begin
                mem_q[s_addr] <= newv;
            end
            if (do_commit) begin
                for (int k = 0; k < TS; k++) begin
                    if (sets_q[sel][k].vld && sets_q[sel][k].excl) begin
                        mem_q[sets_q[sel][k].addr] <= sets_q[sel][k].val;
                    end
                end
                sets_q[sel] <= '0;
            end
        end
    end

endmodule

// File: rtl/tset_chk.sv
module tset_chk
    import tset_pkg::*;
#(
    parameter int unsigned NPROC = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NPROC-1:0]       req_vld,
    input logic [NPROC-1:0]       req_gnt,
    input logic [NPROC-1:0]       rsp_vld,
    input logic [2*NPROC-1:0]     rsp_stat,
    input logic [TX_DW*NPROC-1:0] rsp_data
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(req_gnt)); // R2

    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst) (req_gnt & ~req_vld) == '0); // R2

    AST_RSP_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        (req_gnt != '0) |=> (rsp_vld == $past(req_gnt))); // R2

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_gnt == '0) |=> (rsp_vld == '0)); // R2

    for (genvar gp = 0; gp < NPROC; gp++) begin : g_ab
        AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (rst)
            (rsp_vld[gp] && rsp_stat[gp*2 +: 2] != 2'd0) |-> (rsp_data[gp*TX_DW +: TX_DW] == '0)); // R2
    end
endmodule

bind tset_ctrl tset_chk #(.NPROC(NPROC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_gnt  (req_gnt),
    .rsp_vld  (rsp_vld),
    .rsp_stat (rsp_stat),
    .rsp_data (rsp_data)
);

// File: tb/sim_tset_ctrl.sv
`timescale 1ns/1ps
module sim_tset_ctrl;
    localparam int NP = 3;
    localparam int TSZ = 2;
    localparam logic [1:0] CA = 2'd0, DI = 2'd1, CM = 2'd2;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, AD = 2'd2, CS = 2'd3;
    localparam logic [1:0] OK = 2'd0, CAP = 2'd1, CONF = 2'd2, TRK = 2'd3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   req_vld = '0;
    logic [2*NP-1:0] req_kind = '0;
    logic [2*NP-1:0] req_op = '0;
    logic [4*NP-1:0] req_addr = '0;
    logic [8*NP-1:0] req_wdata = '0;
    logic [8*NP-1:0] req_cmp = '0;
    logic [NP-1:0]   req_gnt;
    logic [NP-1:0]   rsp_vld;
    logic [8*NP-1:0] rsp_data;
    logic [2*NP-1:0] rsp_stat;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tset_ctrl #(.NPROC(NP), .TS(TSZ)) u0 (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_kind(req_kind),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cmp(req_cmp), .req_gnt(req_gnt), .rsp_vld(rsp_vld),
        .rsp_data(rsp_data), .rsp_stat(rsp_stat)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input int p, input logic [1:0] kind, input logic [1:0] op,
                         input logic [3:0] addr, input logic [7:0] wd, input logic [7:0] cmp);
        req_vld[p]          = 1'b1;
        req_kind[p*2 +: 2]  = kind;
        req_op[p*2 +: 2]    = op;
        req_addr[p*4 +: 4]  = addr;
        req_wdata[p*8 +: 8] = wd;
        req_cmp[p*8 +: 8]   = cmp;
    endtask

    // one access; expects status and data one cycle after grant
    task automatic acc(input string tag, input int p, input logic [1:0] kind, input logic [1:0] op,
                       input logic [3:0] addr, input logic [7:0] wd, input logic [7:0] cmp,
                       input logic [1:0] est, input logic [7:0] ed);
        @(negedge clk);
        drive(p, kind, op, addr, wd, cmp);
        @(posedge clk);
        @(negedge clk);
        check(tag, {5'd0, rsp_vld[p], rsp_stat[p*2 +: 2], rsp_data[p*8 +: 8]},
                   {5'd0, 1'b1, est, ed});
        req_vld[p] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 idle outputs", {10'd0, rsp_vld, req_gnt}, 16'd0);
        acc("R1 memory zero", 0, DI, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R1 set empty commit", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
    endtask

    task automatic t_direct();
        acc("R3 store old", 0, DI, WR, 4'd1, 8'h11, 8'h00, OK, 8'h00);
        acc("R3 read", 0, DI, RD, 4'd1, 8'h00, 8'h00, OK, 8'h11);
        acc("R3 add old", 1, DI, AD, 4'd1, 8'h03, 8'h00, OK, 8'h11);
        acc("R3 add result", 1, DI, RD, 4'd1, 8'h00, 8'h00, OK, 8'h14);
        acc("R3 cas hit", 2, DI, CS, 4'd1, 8'h20, 8'h14, OK, 8'h14);
        acc("R3 cas miss", 2, DI, CS, 4'd1, 8'h55, 8'h99, OK, 8'h20);
        acc("R3 cas miss kept", 0, DI, RD, 4'd1, 8'h00, 8'h00, OK, 8'h20);
    endtask

    task automatic t_commit();
        acc("R4 cached store", 1, CA, WR, 4'd2, 8'h22, 8'h00, OK, 8'h00);
        acc("R4 own value", 1, CA, RD, 4'd2, 8'h00, 8'h00, OK, 8'h22);
        acc("R4 second entry", 1, CA, WR, 4'd3, 8'h33, 8'h00, OK, 8'h00);
        acc("R10 commit ok", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R10 word a", 0, DI, RD, 4'd2, 8'h00, 8'h00, OK, 8'h22);
        acc("R10 word b", 0, DI, RD, 4'd3, 8'h00, 8'h00, OK, 8'h33);
    endtask

    task automatic t_abort();
        acc("R4 add pending", 1, CA, AD, 4'd4, 8'h05, 8'h00, OK, 8'h00);
        acc("R4 memory untouched", 0, DI, RD, 4'd4, 8'h00, 8'h00, OK, 8'h00);
        acc("R9 commit tracking abort", 1, CM, RD, 4'd0, 8'h00, 8'h00, TRK, 8'h00);
        acc("R11 memory unchanged", 0, DI, RD, 4'd4, 8'h00, 8'h00, OK, 8'h00);
        acc("R9 valid again", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R8 shared read", 1, CA, RD, 4'd5, 8'h00, 8'h00, OK, 8'h00);
        acc("R8 direct store", 2, DI, WR, 4'd5, 8'h07, 8'h00, OK, 8'h00);
        acc("R9 cached tracking abort", 1, CA, RD, 4'd6, 8'h00, 8'h00, TRK, 8'h00);
        acc("R8 shared again", 1, CA, RD, 4'd5, 8'h00, 8'h00, OK, 8'h07);
        acc("R8 trivial direct", 2, DI, RD, 4'd5, 8'h00, 8'h00, OK, 8'h07);
        acc("R8 still valid", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
    endtask

    task automatic t_conflict();
        acc("R7 hold excl", 0, CA, WR, 4'd6, 8'h66, 8'h00, OK, 8'h00);
        acc("R7 read vs excl", 1, CA, RD, 4'd6, 8'h00, 8'h00, CONF, 8'h00);
        acc("R7 write vs excl", 1, CA, WR, 4'd6, 8'h01, 8'h00, CONF, 8'h00);
        acc("R7 holder unaffected", 0, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 holder published", 2, DI, RD, 4'd6, 8'h00, 8'h00, OK, 8'h66);
        acc("R7 shared a", 0, CA, RD, 4'd7, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 shared b", 1, CA, RD, 4'd7, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 write vs shared", 2, CA, WR, 4'd7, 8'h01, 8'h00, CONF, 8'h00);
        acc("R7 shared a commit", 0, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 shared b commit", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 hold shared", 0, CA, RD, 4'd9, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 pending write", 2, CA, WR, 4'd8, 8'h88, 8'h00, OK, 8'h00);
        acc("R7 conflict clears", 2, CA, WR, 4'd9, 8'h01, 8'h00, CONF, 8'h00);
        acc("R7 empty commit", 2, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R7 holder commit", 0, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R11 dropped write", 1, DI, RD, 4'd8, 8'h00, 8'h00, OK, 8'h00);
    endtask

    task automatic t_capacity();
        acc("R6 fill a", 2, CA, RD, 4'd10, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 fill b", 2, CA, RD, 4'd11, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 new address full", 2, CA, RD, 4'd12, 8'h00, 8'h00, CAP, 8'h00);
        acc("R6 after clear", 2, CA, RD, 4'd10, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 refill", 2, CA, RD, 4'd11, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 held address full", 2, CA, RD, 4'd10, 8'h00, 8'h00, CAP, 8'h00);
        acc("R6 commit empty", 2, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 prio a", 2, CA, RD, 4'd10, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 prio b", 2, CA, WR, 4'd11, 8'h01, 8'h00, OK, 8'h00);
        acc("R8 invalidate", 0, DI, WR, 4'd10, 8'h02, 8'h00, OK, 8'h00);
        acc("R6 cap before track", 2, CA, RD, 4'd12, 8'h00, 8'h00, CAP, 8'h00);
        acc("R6 cleared valid", 2, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R11 cap dropped", 0, DI, RD, 4'd11, 8'h00, 8'h00, OK, 8'h00);
        for (int i = 0; i < 3; i++) begin
            acc("R6 repeat one address", 1, CA, AD, 4'd13, 8'h01, 8'h00, OK, 8'(i));
        end
        acc("R6 repeat commit", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R6 repeat result", 0, DI, RD, 4'd13, 8'h00, 8'h00, OK, 8'h03);
    endtask

    task automatic t_cas();
        acc("R5 cas miss shared", 0, CA, CS, 4'd14, 8'h09, 8'h05, OK, 8'h00);
        acc("R5 co-reader allowed", 1, CA, RD, 4'd14, 8'h00, 8'h00, OK, 8'h00);
        acc("R5 reader commit", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R10 shared commit", 0, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R10 shared not written", 2, DI, RD, 4'd14, 8'h00, 8'h00, OK, 8'h00);
        acc("R5 cas hit excl", 0, CA, CS, 4'd14, 8'h09, 8'h00, OK, 8'h00);
        acc("R5 reader conflicts", 1, CA, RD, 4'd14, 8'h00, 8'h00, CONF, 8'h00);
        acc("R5 cas commit", 0, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R5 cas result", 2, DI, RD, 4'd14, 8'h00, 8'h00, OK, 8'h09);
        acc("R4 upgrade read", 1, CA, RD, 4'd15, 8'h00, 8'h00, OK, 8'h00);
        acc("R4 upgrade write", 1, CA, WR, 4'd15, 8'h5A, 8'h00, OK, 8'h00);
        acc("R10 upgrade commit", 1, CM, RD, 4'd0, 8'h00, 8'h00, OK, 8'h00);
        acc("R10 upgrade result", 0, DI, RD, 4'd15, 8'h00, 8'h00, OK, 8'h5A);
    endtask

    task automatic t_arb();
        @(negedge clk);
        drive(0, DI, RD, 4'd1, 8'h00, 8'h00);
        drive(2, DI, RD, 4'd2, 8'h00, 8'h00);
        #1;
        check("R2 low index granted", {13'd0, req_gnt}, 16'h0001);
        @(posedge clk);
        @(negedge clk);
        check("R2 first response", {5'd0, rsp_vld, rsp_data[7:0]}, {5'd0, 3'b001, 8'h20});
        req_vld[0] = 1'b0;
        #1;
        check("R2 next granted", {13'd0, req_gnt}, 16'h0004);
        @(posedge clk);
        @(negedge clk);
        check("R2 second response", {5'd0, rsp_vld, rsp_data[23:16]}, {5'd0, 3'b100, 8'h22});
        req_vld[2] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_commit();
        t_abort();
        t_conflict();
        t_capacity();
        t_cas();
        t_arb();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #2000000;
        nvec++;
        nfail++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end
endmodule